// File: doc/BRIEF.md
# Step Attenuator Control Front End

This block produces the registered 6-bit code that drives the switch array of a 0.5 dB-per-step attenuator, so the code spans 0 to 31.5 dB. The control word reaches it in one of two ways. In serial mode, data bits are clocked into a shift register by a slow serial clock. In parallel mode, the word is taken directly from six control pins. In both modes a rising edge on the latch strobe copies the pending word into the output register. The shift register's last stage is brought out as a serial output, so several attenuators can be chained on one data line.

At reset, two preset-select pins choose the starting attenuation. That value stays in place until the first latch strobe. All serial-clock and strobe activity is sampled in one fast system clock domain. Timing rules are therefore counted in system clock cycles. A strobe that arrives too soon after the previous one raises a one-cycle warning, but the latch still takes place.

Top module: `attn_ctl_top`

## Requirements
- R1: While `rst_n` is low, `att_code` takes the preset chosen by `pup_sel`: 0 gives code 0 (0 dB), 1 gives code 16 (8 dB), 2 gives code 32 (16 dB) and 3 gives code 63 (31.5 dB).
- R2: `att_code` changes only in the cycle after a rising edge of `le` is sampled. Without such an edge it holds, and this includes holding the reset preset.
- R3: A rising edge of `le` with `mode_ser` low (parallel mode) loads `par_word` into `att_code`. The new value is visible after the same clock edge.
- R4: A rising edge of `le` with `mode_ser` high (serial mode) loads the shift register. Bits are shifted in most significant bit first, so the first of six bits lands in bit 5.
- R5: A rising edge of `sclk` shifts `sdi` in only while `le` is low. Rising edges while `le` is high leave the shift register and `sdo` unchanged.
- R6: `sdo` shows the oldest stage of the six-stage shift register. A bit shifted in appears on `sdo` after five further shifts and leaves on the sixth, so the delay is six serial clocks.
- R7: A change of `mode_ser` alone never alters `att_code`. It only selects the source for the next latch.
- R8: When two rising edges of `le` are fewer than `MIN_LE_GAP` system cycles apart, `le_gap_err` is high for exactly the one cycle after the second edge, and the latch still happens. The first edge after reset never raises it.
- R9: Rising edges of `le` that are `MIN_LE_GAP` or more cycles apart leave `le_gap_err` low.
- R10: When `sclk` and `le` rise in the same cycle, no shift occurs and the latch takes the shift register contents from before that cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System sampling clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mode_ser | input | 1 | 0 = parallel source, 1 = serial source |
| sclk | input | 1 | Serial clock, sampled |
| sdi | input | 1 | Serial data in |
| le | input | 1 | Latch strobe, acts on its rising edge |
| par_word | input | 6 | Parallel control word |
| pup_sel | input | 2 | Reset preset select |
| att_code | output | 6 | Registered attenuation code |
| sdo | output | 1 | Chain output, last shift stage |
| le_gap_err | output | 1 | One-cycle strobe spacing warning |

## Verification
A serial clock rise and a latch strobe rise can fall in the same sampled cycle. In that cycle the latch must win, and the shift must be dropped. The bench provokes this by raising `sclk` and `le` together after a known serial word has been loaded. It then judges three things: that `att_code` equals the word from before the collision, that `sdo` has not moved, and that a later latch still shows the unshifted contents. Random runs also place strobes at gaps on both sides of the spacing limit, so the warning can coincide with a latch.

// File: rtl/attn_ctl_pkg.sv
package attn_ctl_pkg;
  typedef enum logic {
    SRC_PAR = 1'b0,
    SRC_SER = 1'b1
  } src_sel_e;

  typedef enum logic [1:0] {
    PRE_MIN  = 2'd0,
    PRE_QTR  = 2'd1,
    PRE_HALF = 2'd2,
    PRE_MAX  = 2'd3
  } preset_e;
endpackage

// File: rtl/attn_edge_det.sv
module attn_edge_det #(
  parameter int N = 2
) (
  input  logic         clk,
  input  logic [N-1:0] sig,
  output logic [N-1:0] rise
);
  logic [N-1:0] sig_d;

  for (genvar i = 0; i < N; i++) begin : g_bit
    always_ff @(posedge clk) sig_d[i] <= sig[i];
    assign rise[i] = sig[i] & ~sig_d[i];
  end
endmodule

// File: rtl/attn_shift_reg.sv
module attn_shift_reg #(
  parameter int WIDTH = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             shift_en,
  input  logic             din,
  output logic [WIDTH-1:0] q,
  output logic             dout
);
  always_ff @(posedge clk) begin
    if (!rst_n)        q <= '0;
    else if (shift_en) q <= {q[WIDTH-2:0], din};
  end

  assign dout = q[WIDTH-1];
endmodule

// File: rtl/attn_gap_mon.sv
module attn_gap_mon #(
  parameter int MIN_GAP = 158
) (
  input  logic clk,
  input  logic rst_n,
  input  logic strobe,
  output logic too_soon
);
  localparam int CNT_W = $clog2(MIN_GAP + 1);
  localparam logic [CNT_W-1:0] LIMIT = CNT_W'(MIN_GAP);

  logic [CNT_W-1:0] gap_cnt;
  logic             armed;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      gap_cnt  <= '0;
      armed    <= 1'b0;
      too_soon <= 1'b0;
    end else begin
      too_soon <= strobe && armed && (gap_cnt < LIMIT);
      if (strobe) begin
        gap_cnt <= CNT_W'(1);
        armed   <= 1'b1;
      end else if (gap_cnt < LIMIT) begin
        gap_cnt <= gap_cnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/attn_ctl_top.sv
module attn_ctl_top #(
  parameter int WORD_W     = 6,
  parameter int MIN_LE_GAP = 158
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mode_ser,
  input  logic              sclk,
  input  logic              sdi,
  input  logic              le,
  input  logic [WORD_W-1:0] par_word,
  input  logic [1:0]        pup_sel,
  output logic [WORD_W-1:0] att_code,
  output logic              sdo,
  output logic              le_gap_err
);
  import attn_ctl_pkg::*;

  localparam int EDGE_N = 2;
  localparam int IDX_SCLK = 0;
  localparam int IDX_LE = 1;

  function automatic logic [WORD_W-1:0] preset_code(input logic [1:0] sel);
    logic [WORD_W-1:0] v;
    v = '0;
    case (preset_e'(sel))
      PRE_MIN:  v = '0;
      PRE_QTR:  v[WORD_W-2] = 1'b1;
      PRE_HALF: v[WORD_W-1] = 1'b1;
      default:  v = '1;
    endcase
    return v;
  endfunction

  logic [EDGE_N-1:0] rise;
  logic              sclk_rise, le_rise;
  logic [WORD_W-1:0] shq;
  logic [WORD_W-1:0] att_q;

  attn_edge_det #(.N(EDGE_N)) u_edge (
    .clk  (clk),
    .sig  ({le, sclk}),
    .rise (rise)
  );

  assign sclk_rise = rise[IDX_SCLK];
  assign le_rise   = rise[IDX_LE];

  attn_shift_reg #(.WIDTH(WORD_W)) u_shift (
    .clk      (clk),
    .rst_n    (rst_n),
    .shift_en (sclk_rise && !le),
    .din      (sdi),
    .q        (shq),
    .dout     (sdo)
  );

  attn_gap_mon #(.MIN_GAP(MIN_LE_GAP)) u_gap (
    .clk      (clk),
    .rst_n    (rst_n),
    .strobe   (le_rise),
    .too_soon (le_gap_err)
  );

  always_ff @(posedge clk) begin
    if (!rst_n)       att_q <= preset_code(pup_sel);
    else if (le_rise) att_q <= (src_sel_e'(mode_ser) == SRC_SER) ? shq : par_word;
  end

  assign att_code = att_q;
endmodule

// File: rtl/attn_ctl_chk.sv
module attn_ctl_chk #(
  parameter int WORD_W = 6
) (
  input logic              clk,
  input logic              rst_n,
  input logic              mode_ser,
  input logic              sclk,
  input logic              le,
  input logic [WORD_W-1:0] par_word,
  input logic [1:0]        pup_sel,
  input logic [WORD_W-1:0] att_code,
  input logic              sdo,
  input logic              le_gap_err,
  input logic [WORD_W-1:0] shq
);
  function automatic logic [WORD_W-1:0] exp_preset(input logic [1:0] sel);
    logic [WORD_W-1:0] v;
    v = '0;
    if (sel == 2'd1) v[WORD_W-2] = 1'b1;
    else if (sel == 2'd2) v[WORD_W-1] = 1'b1;
    else if (sel == 2'd3) v = '1;
    return v;
  endfunction

  // R1
  preset_on_release_chk: assert property (@(posedge clk)
    $rose(rst_n) |-> att_code == exp_preset($past(pup_sel)));

  // R2
  att_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(le && !$past(le)) |=> $stable(att_code));

  // R3
  par_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (le && !$past(le) && !mode_ser) |=> att_code == $past(par_word));

  // R4
  ser_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (le && !$past(le) && mode_ser) |=> att_code == $past(shq));

  // R5
  sdo_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (le || !(sclk && !$past(sclk))) |=> $stable(sdo));

  // R8
  gap_err_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    le_gap_err |-> ($past(le) && !$past(le, 2)));
endmodule

bind attn_ctl_top attn_ctl_chk #(.WORD_W(WORD_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .mode_ser   (mode_ser),
  .sclk       (sclk),
  .le         (le),
  .par_word   (par_word),
  .pup_sel    (pup_sel),
  .att_code   (att_code),
  .sdo        (sdo),
  .le_gap_err (le_gap_err),
  .shq        (shq)
);

// File: tb/tb_attn_ctl_top.sv
`timescale 1ns/1ps
module tb_attn_ctl_top;
  localparam int W = 6;
  localparam int GAP = 158;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic mode_ser = 1'b0, sclk = 1'b0, sdi = 1'b0, le = 1'b0;
  logic [W-1:0] par_word = '0;
  logic [1:0] pup_sel = 2'd0;
  logic [W-1:0] att_code;
  logic sdo, le_gap_err;

  int total = 0, bad = 0, cyc = 0;
  logic [W-1:0] m_sh, m_att;
  int m_last;
  bit m_armed;

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  attn_ctl_top #(.WORD_W(W), .MIN_LE_GAP(GAP)) dut (
    .clk(clk), .rst_n(rst_n), .mode_ser(mode_ser), .sclk(sclk), .sdi(sdi),
    .le(le), .par_word(par_word), .pup_sel(pup_sel), .att_code(att_code),
    .sdo(sdo), .le_gap_err(le_gap_err));

  function automatic logic [W-1:0] preset(input logic [1:0] s);
    case (s)
      2'd0: return 6'd0;
      2'd1: return 6'd16;
      2'd2: return 6'd32;
      default: return 6'd63;
    endcase
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_reset(input logic [1:0] p);
    @(negedge clk);
    rst_n = 1'b0; pup_sel = p; sclk = 0; le = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    m_sh = '0; m_armed = 0; m_att = preset(p);
    @(negedge clk);
    check(att_code == m_att, "R1 preset", att_code, m_att);
  endtask

  task automatic do_shift(input logic b);
    @(negedge clk);
    sdi = b; sclk = 1'b1;
    @(negedge clk);
    if (!le) m_sh = {m_sh[W-2:0], b};
    sclk = 1'b0;
    check(sdo == m_sh[W-1], "R6 sdo", sdo, m_sh[W-1]);
  endtask

  task automatic do_latch(input string req);
    logic exp_err;
    @(negedge clk);
    le = 1'b1;
    @(negedge clk);
    exp_err = m_armed && ((cyc - m_last) < GAP);
    m_armed = 1; m_last = cyc;
    m_att = mode_ser ? m_sh : par_word;
    check(att_code == m_att, req, att_code, m_att);
    check(le_gap_err == exp_err, exp_err ? "R8 gap err" : "R9 no gap err", le_gap_err, exp_err);
    le = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic sdo_before;
    void'($urandom(32'd2024));
    for (int p = 0; p < 4; p++) do_reset(2'(p));

    // R2: preset held with activity but no strobe
    par_word = 6'd5; mode_ser = 1'b0;
    do_shift(1'b1);
    repeat (10) @(negedge clk);
    check(att_code == m_att, "R2 hold preset", att_code, m_att);

    // R3: parallel load, first strobe never flags (R8)
    par_word = 6'd42;
    do_latch("R3 par load");

    // R4: serial MSB first, 101100
    mode_ser = 1'b1;
    for (int i = W - 1; i >= 0; i--) do_shift(6'b101100 >> i);
    repeat (GAP) @(negedge clk);
    do_latch("R4 ser load");
    check(att_code == 6'b101100, "R4 msb first", att_code, 6'b101100);

    // R7: mode toggle alone
    mode_ser = 1'b0; repeat (4) @(negedge clk);
    mode_ser = 1'b1; repeat (4) @(negedge clk);
    check(att_code == m_att, "R7 mode no effect", att_code, m_att);

    // R8: too-soon strobe still latches
    mode_ser = 1'b0; par_word = 6'd9;
    repeat (5) @(negedge clk);
    do_latch("R8 latch still done");

    // R5: sclk edges while le high ignored
    repeat (GAP) @(negedge clk);
    @(negedge clk); le = 1'b1;
    @(negedge clk);
    m_armed = 1; m_last = cyc; m_att = par_word;
    sdo_before = sdo;
    for (int i = 0; i < 3; i++) do_shift(~sdo_before);
    check(sdo == sdo_before, "R5 sdo unchanged", sdo, sdo_before);
    le = 1'b0;

    // R10: sclk and le rise together
    repeat (GAP) @(negedge clk);
    mode_ser = 1'b1;
    sdo_before = sdo;
    @(negedge clk);
    sdi = ~m_sh[W-1]; sclk = 1'b1; le = 1'b1;
    @(negedge clk);
    m_armed = 1; m_last = cyc; m_att = m_sh;
    check(att_code == m_att, "R10 latch pre-shift", att_code, m_att);
    check(sdo == sdo_before, "R10 no shift", sdo, sdo_before);
    sclk = 1'b0; le = 1'b0;
    repeat (GAP) @(negedge clk);
    do_latch("R10 contents kept");

    // random mix
    for (int it = 0; it < 60; it++) begin
      int nsh, idle;
      mode_ser = 1'($urandom);
      par_word = W'($urandom);
      nsh = $urandom % 9;
      for (int k = 0; k < nsh; k++) do_shift(1'($urandom));
      idle = ($urandom % 2) ? ($urandom % 40) : ($urandom % 220);
      repeat (idle) @(negedge clk);
      do_latch(mode_ser ? "R4 rand ser" : "R3 rand par");
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule